// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps addresses that fall in a local outbound memory region onto wide target addresses on the far side of a PCIe link. The local region is divided into a table of equal-size windows. Each window has a programmable 64-bit target base and a valid flag. One size register sets the size of every window to a power-of-two number of megabytes. A global enable bit turns translation on or off for the whole table.

A lookup is presented as a local address with a one-cycle valid strobe. The window index is the distance from the region base divided by the window size. The target address is that window's base plus the remainder. One cycle later the block returns the translated address with a hit flag, or a miss flag with a zero address. Software programs the table through a simple word-write port whose offsets are fixed by the decode below.

Top module: `ob_addr_xlat`

## Requirements
- R1: After a synchronous active-low reset, out_valid, out_hit and out_miss are low, translation is disabled, the size index is 0 (1 MB windows) and every window is invalid.
- R2: Each cycle with in_valid high yields exactly one cycle of out_valid on the next clock edge, back to back with no gaps; out_valid is low otherwise.
- R3: Register decode uses exact word offsets: offset 0x004 bit 1 is the translation enable; offset 0x030 bits [2:0] hold the size index s; window i has its low word at 0x200 + 8*i and its high word at 0x204 + 8*i. Bit 0 of a low word is the window's valid flag.
- R4: Windows are (1 << s) MB each. The window index is (in_addr - REGION_BASE) >> (20 + s), so consecutive windows cover consecutive regions, and a change of s takes effect on the next lookup.
- R5: On a hit, out_addr = {high word, low word with bit 0 cleared} + ((in_addr - REGION_BASE) mod window size), as a full 64-bit sum with carry from the low half into the high half.
- R6: While translation is disabled every lookup misses.
- R7: A lookup that lands in a window whose valid flag is 0 misses.
- R8: A lookup below REGION_BASE, or whose window index is 32 or more, misses; the last byte of window 31 still hits.
- R9: With out_valid high, exactly one of out_hit and out_miss is high, and out_addr is zero on a miss.
- R10: Writes to offsets outside the map in R3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Lookup strobe |
| in_addr | input | 32 | Local address to translate |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_hit | output | 1 | Address was translated |
| out_miss | output | 1 | Address was not translated |
| out_addr | output | 64 | Translated target address, zero on a miss |

## Verification
The embedded assertions check on every cycle the one-cycle strobe latency, the exclusive hit or miss flag and the zero address on a miss. They also check that a disabled table always misses and that enable and size writes land in their registers. Only the bench scenarios can show that the arithmetic is correct: the window index for several size settings, the offset and carry into the high word, the range edges at the region base and past window 31, and the invalid-window misses. The bench scenarios also show that writes to unmapped offsets leave translations unchanged.

// File: rtl/ob_xlat_pkg.sv
// Shared constants and types for the outbound window translator.
// Assumes byte offsets on the register port and 1 MB as the smallest window.
package ob_xlat_pkg;
    localparam int MB_SHIFT    = 20;      // log2 of one megabyte
    localparam int CMD_OFF     = 'h004;   // command word, enable bit below
    localparam int XLAT_EN_BIT = 1;
    localparam int SIZE_OFF    = 'h030;   // size index word
    localparam int TBL_OFF     = 'h200;   // first window low word
    localparam int TBL_STRIDE  = 8;       // bytes per window entry
    localparam int HI_STEP     = 4;       // high word after low word

    typedef enum logic [1:0] {
        CAUSE_HIT   = 2'd0,
        CAUSE_OFF   = 2'd1,
        CAUSE_RANGE = 2'd2,
        CAUSE_EMPTY = 2'd3
    } xlat_cause_t;
endpackage

// File: rtl/ob_xlat_regs.sv
// Register file of the translator: enable bit, size index and the
// per-window low/high words. Assumes exact word-offset decode; any
// other offset is ignored.
module ob_xlat_regs
    import ob_xlat_pkg::*;
#(
    parameter int NUM_WIN = 32,
    parameter int REG_AW  = 12,
    parameter int REG_DW  = 32,
    parameter int SIZE_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [REG_DW-1:0] cfg_wdata,
    output logic              xlat_en,
    output logic [SIZE_W-1:0] win_size,
    output logic [REG_DW-1:0] win_lo [NUM_WIN],
    output logic [REG_DW-1:0] win_hi [NUM_WIN]
);
    localparam logic [REG_AW-1:0] CMD_A  = REG_AW'(CMD_OFF);
    localparam logic [REG_AW-1:0] SIZE_A = REG_AW'(SIZE_OFF);

    // Global translation enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            xlat_en <= 1'b0;
        else if (cfg_we && cfg_addr == CMD_A)
            xlat_en <= cfg_wdata[XLAT_EN_BIT];
    end

    // Window size index shared by all windows.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_size <= '0;
        else if (cfg_we && cfg_addr == SIZE_A)
            win_size <= cfg_wdata[SIZE_W-1:0];
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam logic [REG_AW-1:0] LO_A = REG_AW'(TBL_OFF + TBL_STRIDE * i);
        localparam logic [REG_AW-1:0] HI_A = REG_AW'(TBL_OFF + TBL_STRIDE * i + HI_STEP);

        // Low word of window i; bit 0 is its valid flag.
        always_ff @(posedge clk) begin
            if (!rst_n)
                win_lo[i] <= '0;
            else if (cfg_we && cfg_addr == LO_A)
                win_lo[i] <= cfg_wdata;
        end

        // High word of window i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                win_hi[i] <= '0;
            else if (cfg_we && cfg_addr == HI_A)
                win_hi[i] <= cfg_wdata;
        end
    end

    assert_en_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CMD_A) |=> (xlat_en == $past(cfg_wdata[XLAT_EN_BIT])));

    assert_size_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == SIZE_A) |=> (win_size == $past(cfg_wdata[SIZE_W-1:0])));
endmodule

// File: rtl/ob_xlat_lookup.sv
// Combinational window lookup: derives the window index from the local
// address and size index, classifies the lookup and forms the target
// address. Assumes the region starts at REGION_BASE.
module ob_xlat_lookup
    import ob_xlat_pkg::*;
#(
    parameter int                NUM_WIN     = 32,
    parameter int                LOC_AW      = 32,
    parameter int                REG_DW      = 32,
    parameter int                SIZE_W      = 3,
    parameter logic [LOC_AW-1:0] REGION_BASE = 'h8000_0000
) (
    input  logic [LOC_AW-1:0]   loc_addr,
    input  logic                xlat_en,
    input  logic [SIZE_W-1:0]   win_size,
    input  logic [REG_DW-1:0]   win_lo [NUM_WIN],
    input  logic [REG_DW-1:0]   win_hi [NUM_WIN],
    output xlat_cause_t         cause,
    output logic [2*REG_DW-1:0] tgt_addr
);
    localparam int TGT_AW  = 2 * REG_DW;
    localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam int SHIFT_W = $clog2(MB_SHIFT + (1 << SIZE_W) + 1);

    logic [LOC_AW-1:0]  diff;
    logic [LOC_AW-1:0]  idx_full;
    logic [LOC_AW-1:0]  off_mask;
    logic [SHIFT_W-1:0] shift;
    logic [IDX_W-1:0]   idx;

    // Index, offset, target sum and lookup class.
    always_comb begin
        diff     = loc_addr - REGION_BASE;
        shift    = SHIFT_W'(MB_SHIFT) + SHIFT_W'(win_size);
        idx_full = diff >> shift;
        off_mask = (LOC_AW'(1) << shift) - LOC_AW'(1);
        idx      = idx_full[IDX_W-1:0];
        tgt_addr = {win_hi[idx], win_lo[idx] & ~REG_DW'(1)} + TGT_AW'(diff & off_mask);
        if (!xlat_en)
            cause = CAUSE_OFF;
        else if (loc_addr < REGION_BASE || idx_full >= LOC_AW'(NUM_WIN))
            cause = CAUSE_RANGE;
        else if (!win_lo[idx][0])
            cause = CAUSE_EMPTY;
        else
            cause = CAUSE_HIT;
    end
endmodule

// File: rtl/ob_addr_xlat.sv
// Outbound address window translator top: register file, lookup and a
// single result register. Assumes one lookup per cycle at most and
// returns each result exactly one cycle after its strobe.
module ob_addr_xlat
    import ob_xlat_pkg::*;
#(
    parameter int                NUM_WIN     = 32,
    parameter int                LOC_AW      = 32,
    parameter int                REG_AW      = 12,
    parameter int                REG_DW      = 32,
    parameter int                SIZE_W      = 3,
    parameter logic [LOC_AW-1:0] REGION_BASE = 'h8000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [REG_AW-1:0]   cfg_addr,
    input  logic [REG_DW-1:0]   cfg_wdata,
    input  logic                in_valid,
    input  logic [LOC_AW-1:0]   in_addr,
    output logic                out_valid,
    output logic                out_hit,
    output logic                out_miss,
    output logic [2*REG_DW-1:0] out_addr
);
    localparam int TGT_AW = 2 * REG_DW;

    logic              xlat_en;
    logic [SIZE_W-1:0] win_size;
    logic [REG_DW-1:0] win_lo [NUM_WIN];
    logic [REG_DW-1:0] win_hi [NUM_WIN];
    xlat_cause_t       cause;
    logic [TGT_AW-1:0] tgt_addr;

    ob_xlat_regs #(
        .NUM_WIN(NUM_WIN), .REG_AW(REG_AW), .REG_DW(REG_DW), .SIZE_W(SIZE_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .xlat_en(xlat_en), .win_size(win_size),
        .win_lo(win_lo), .win_hi(win_hi)
    );

    ob_xlat_lookup #(
        .NUM_WIN(NUM_WIN), .LOC_AW(LOC_AW), .REG_DW(REG_DW), .SIZE_W(SIZE_W),
        .REGION_BASE(REGION_BASE)
    ) u_lookup (
        .loc_addr(in_addr), .xlat_en(xlat_en), .win_size(win_size),
        .win_lo(win_lo), .win_hi(win_hi), .cause(cause), .tgt_addr(tgt_addr)
    );

    // Result register: one cycle from strobe, address zero unless a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_miss  <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            out_hit   <= in_valid && (cause == CAUSE_HIT);
            out_miss  <= in_valid && (cause != CAUSE_HIT);
            out_addr  <= (in_valid && cause == CAUSE_HIT) ? tgt_addr : '0;
        end
    end

    assert_strobe_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_one_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot({out_hit, out_miss}));

    assert_idle_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_hit || out_miss));

    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_miss |-> (out_addr == '0));

    assert_disabled_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !xlat_en) |=> out_miss);
endmodule

// File: tb/ob_addr_xlat_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push predicted results, a monitor pops
// and compares them at the cycle each result is due.
module ob_addr_xlat_tb;
    localparam logic [31:0] BASE = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid, out_hit, out_miss;
    logic [63:0] out_addr;

    always #5 clk = ~clk;

    ob_addr_xlat u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_addr(in_addr),
        .out_valid(out_valid), .out_hit(out_hit), .out_miss(out_miss),
        .out_addr(out_addr)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference state built from the register map.
    logic [31:0] m_lo [32];
    logic [31:0] m_hi [32];
    logic        m_en = 1'b0;
    logic [2:0]  m_s = 3'd0;

    typedef struct packed {
        logic [31:0] due;
        logic        hit;
        logic [63:0] addr;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t predict(input logic [31:0] a, input int due);
        exp_t        e;
        logic [31:0] d;
        logic [31:0] idx;
        int          sh;
        sh     = 20 + int'(m_s);
        d      = a - BASE;
        idx    = d >> sh;
        e.due  = due;
        e.hit  = 1'b0;
        e.addr = '0;
        if (m_en && a >= BASE && idx < 32 && m_lo[idx[4:0]][0]) begin
            e.hit  = 1'b1;
            e.addr = {m_hi[idx[4:0]], m_lo[idx[4:0]] & 32'hFFFF_FFFE}
                     + {32'h0, d & ((32'h1 << sh) - 32'h1)};
        end
        return e;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        in_valid  = 1'b0;
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        if (a == 12'h004) m_en = d[1];
        else if (a == 12'h030) m_s = d[2:0];
        else if (a >= 12'h200 && a < 12'h300 && a[1:0] == 2'b00) begin
            if (a[2]) m_hi[(a - 12'h200) >> 3] = d;
            else      m_lo[(a - 12'h200) >> 3] = d;
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input logic [31:0] a, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        exp_q.push_back(predict(a, cyc + 1));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare each due result, flag any unrequested one.
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(out_valid == 1'b1, {t, "/R2"}, "out_valid", 64'(out_valid), 64'd1);
                chk(out_hit == e.hit, t, "out_hit", 64'(out_hit), 64'(e.hit));
                chk(out_miss == !e.hit, {t, "/R9"}, "out_miss", 64'(out_miss), 64'(!e.hit));
                chk(out_addr == e.addr, t, "out_addr", out_addr, e.addr);
            end else if (out_valid) begin
                chk(1'b0, "R2", "unexpected out_valid", 64'(out_valid), 64'd0);
            end
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_lo[i] = '0;
            m_hi[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_hit == 1'b0 && out_miss == 1'b0, "R1",
            "flags in reset", {61'd0, out_valid, out_hit, out_miss}, 64'd0);
        rst_n = 1'b1;
        idle(2);

        // R6: disabled after reset, everything misses.
        look(BASE + 32'h40, "R6");
        idle(1);
        // R1: enabled but tables empty; size index 0 gives 1 MB windows.
        wr(12'h004, 32'h2);
        look(BASE + 32'h40, "R1");
        idle(1);
        wr(12'h208, 32'h1000_0001);
        look(BASE + 32'h0010_0040, "R1");
        look(BASE + 32'h0000_0040, "R1");
        idle(2);

        // R3/R4/R5: 8 MB windows, consecutive target blocks.
        wr(12'h030, 32'h3);
        for (int i = 0; i < 4; i++) begin
            wr(12'(12'h200 + 8 * i), 32'h4000_0001 + 32'(i) * 32'h0080_0000);
            wr(12'(12'h204 + 8 * i), 32'h0);
        end
        wr(12'h228, 32'h1230_0001);
        wr(12'h22C, 32'h0000_0002);
        wr(12'h2F8, 32'hFFF0_0001);
        wr(12'h2FC, 32'hDEAD_0000);
        // back-to-back strobes
        look(BASE + 32'h0000_0004, "R4");
        look(BASE + 32'h0080_0010, "R4");
        look(BASE + 32'h017F_FFFF, "R4");
        look(BASE + 32'h0280_1234, "R5");
        look(32'h8FFF_FFFF, "R5");
        look(BASE + 32'h0200_0000, "R7");
        look(32'h7FFF_FFF0, "R8");
        look(32'h9000_0000, "R8");
        idle(2);

        // R7: clearing the valid flag of window 2.
        wr(12'h210, 32'h4100_0000);
        look(BASE + 32'h0100_0020, "R7");
        idle(1);

        // R6: disable then re-enable.
        wr(12'h004, 32'h0);
        look(BASE + 32'h0000_0004, "R6");
        idle(1);
        wr(12'h004, 32'h2);
        look(BASE + 32'h0000_0004, "R6");
        idle(1);

        // R4: size change takes effect on the next lookup.
        wr(12'h030, 32'h7);
        look(BASE + 32'h0800_0005, "R4");
        idle(1);
        wr(12'h030, 32'h0);
        look(BASE + 32'h0030_0010, "R4");
        look(BASE + 32'h0200_0000, "R8");
        idle(1);
        wr(12'h030, 32'h3);

        // R10: unmapped offsets leave every translation unchanged.
        wr(12'h300, 32'hFFFF_FFFF);
        wr(12'h008, 32'hFFFF_FFFF);
        wr(12'h202, 32'hFFFF_FFFF);
        wr(12'h034, 32'hFFFF_FFFF);
        look(BASE + 32'h0000_0100, "R10");
        look(BASE + 32'h0200_0000, "R10");
        look(32'h8FFF_0000, "R10");
        idle(3);

        chk(exp_q.size() == 0, "R2", "results outstanding", 64'(exp_q.size()), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog", "run did not finish", 64'(cyc), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule